// File: doc/BRIEF.md
# I2C Memory and Tag Slave Front End

This block is the serial-bus side of a memory or dynamic tag. It watches the two bus wires through synchronisers running on the system clock and finds start and stop conditions. It takes bytes in most significant bit first and checks the first byte of each transfer against its own identity. It acknowledges a match and stays silent on everything else. Once a transfer is accepted, the block moves bytes to or from a simple byte-wide memory port. A memory, or the logic that builds replies, sits on that port.

A two-bit mode input selects one of three behaviours:

- **Standard memory mode.** All three chip-enable bits of the select byte are compared with pins. A two-byte address comes next.
- **Tag mode.** The top chip-enable bit is compared with a build-time constant instead of a pin.
- **Command/response mode.** There is no address phase. A write-direction transfer delivers a command. A later read-direction transfer collects the prepared reply.

The address pointer lives in the block and persists between transfers. This supports random reads (address write, then repeated start) and current-address reads.

Top module: `i2cs_tag_slave`

## Requirements
- R1: A start is SDA falling while SCL is high; a stop is SDA rising while SCL is high. Either one, at any bit position, abandons the byte in progress, and the byte after a start is always treated as a fresh select byte.
- R2: The select byte is received MSB first. Its bits 7..4 must equal 1010; any other value is not acknowledged, and the rest of that transfer is ignored (no acknowledge, no memory write strobe).
- R3: Bit 0 of the select byte is the direction (1 = slave sends). With mode_i = 0 (standard) or 2 (command), bits 3..1 must equal chip_en_i[2:0]. With mode_i = 1 (tag), bit 3 must equal parameter TAG_E2 and bits 2..1 must equal chip_en_i[1:0]; chip_en_i[2] is ignored.
- R4: For every byte it accepts, the slave pulls SDA low (sda_oe_o = 1) during the ninth SCL clock, and sda_oe_o only changes while SCL is low.
- R5: In standard and tag mode, a write select is followed by an address high byte and an address low byte, which set the pointer to the low ADDR_W bits of {high, low}. Each further byte gives a one-cycle mem_we_o at the pointer, and the pointer then increments modulo 2^ADDR_W.
- R6: After a read select in standard or tag mode, the slave sends the byte at the pointer, MSB first, for each byte the master acknowledges, with a one-cycle mem_re_o per byte. The pointer increments after each byte sent and is kept across transfers.
- R7: When the master answers a sent byte with NACK, the slave releases SDA and drives nothing until the next start.
- R8: In command mode, bytes following a write select (no address phase) are written at addresses 0, 1, 2 and so on. A command of at least one byte that ends with a stop or start makes a reply pending.
- R9: In command mode, a read select is acknowledged only while a reply is pending. Acknowledging it clears the pending state, and the reply is read from address 0 upward.
- R10: After reset, sda_oe_o, mem_we_o and mem_re_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock wire level |
| sda_i | input | 1 | Bus data wire level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| mode_i | input | 2 | 0 standard, 1 tag, 2 command/response |
| chip_en_i | input | 3 | Chip-enable pin levels E2..E0 |
| mem_addr_o | output | ADDR_W | Memory port address (pointer) |
| mem_we_o | output | 1 | One-cycle write strobe |
| mem_wdata_o | output | 8 | Write data |
| mem_re_o | output | 1 | One-cycle read strobe; mem_rdata_i sampled in the same cycle |
| mem_rdata_i | input | 8 | Read data for mem_addr_o, combinational |

## Verification
A wrong bit count inside the byte framer shows up within one byte: the acknowledge appears on the wrong SCL clock or is missing, and the master samples it on the ninth clock. A wrong pointer stays hidden until the next read, where the first data byte returned differs from the byte the bench computed for that address. A stale or missing pending-reply flag shows up on the very next command-mode read select, as a wrong acknowledge. A slave that keeps driving after a NACK is caught by reading one more byte with no start, which must return all ones.

// File: rtl/i2cs_pkg.sv
`timescale 1ns/1ps
package i2cs_pkg;
  localparam logic [1:0] MODE_STD = 2'd0;
  localparam logic [1:0] MODE_TAG = 2'd1;
  localparam logic [1:0] MODE_CMD = 2'd2;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADDR_HI,
    ST_ADDR_LO,
    ST_WDATA,
    ST_RDATA
  } i2cs_state_e;
endpackage

// File: rtl/i2cs_sync.sv
`timescale 1ns/1ps
module i2cs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // conditions only with SCL steady high
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2cs_framer.sv
`timescale 1ns/1ps
module i2cs_framer (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       sda_i,
  input  logic       frame_rst_i,
  output logic       byte_rdy_o,
  output logic [7:0] rx_byte_o,
  output logic       ack_rdy_o,
  output logic       ack_bit_o,
  output logic       bit_fall_o,
  output logic       slot_fall_o,
  output logic       end_fall_o
);
  localparam logic [3:0] CNT_LAST = 4'd9;

  logic [3:0] cnt_q;
  logic [7:0] rx_q;
  logic       byte_rdy_q, ack_rdy_q, ack_bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      rx_q       <= '0;
      byte_rdy_q <= 1'b0;
      ack_rdy_q  <= 1'b0;
      ack_bit_q  <= 1'b1;
    end else begin
      byte_rdy_q <= 1'b0;
      ack_rdy_q  <= 1'b0;
      if (frame_rst_i) begin
        cnt_q <= '0;
      end else if (scl_rise_i && cnt_q < CNT_LAST) begin
        cnt_q <= cnt_q + 4'd1;
        if (cnt_q < 4'd8) rx_q <= {rx_q[6:0], sda_i};
        if (cnt_q == 4'd7) byte_rdy_q <= 1'b1;
        if (cnt_q == 4'd8) begin
          ack_rdy_q <= 1'b1;
          ack_bit_q <= sda_i;
        end
      end else if (scl_fall_i && cnt_q == CNT_LAST) begin
        cnt_q <= '0;
      end
    end
  end

  assign byte_rdy_o  = byte_rdy_q;
  assign rx_byte_o   = rx_q;
  assign ack_rdy_o   = ack_rdy_q;
  assign ack_bit_o   = ack_bit_q;
  assign bit_fall_o  = scl_fall_i && (cnt_q >= 4'd1) && (cnt_q <= 4'd7);
  assign slot_fall_o = scl_fall_i && (cnt_q == 4'd8);
  assign end_fall_o  = scl_fall_i && (cnt_q == CNT_LAST);

  AST_FRAME_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_rst_i |=> (cnt_q == 4'd0)); // R1
endmodule

// File: rtl/i2cs_select.sv
`timescale 1ns/1ps
module i2cs_select
  import i2cs_pkg::*;
#(
  parameter bit TAG_E2 = 1'b1
) (
  input  logic [7:0] sel_byte_i,
  input  logic [1:0] mode_i,
  input  logic [2:0] chip_en_i,
  output logic       hit_o
);
  logic [2:0] own_ce;

  always_comb begin
    own_ce = chip_en_i;
    if (mode_i == MODE_TAG) own_ce[2] = TAG_E2;
    hit_o = (sel_byte_i[7:4] == DEV_TYPE) && (sel_byte_i[3:1] == own_ce);
  end
endmodule

// File: rtl/i2cs_tag_slave.sv
`timescale 1ns/1ps
module i2cs_tag_slave
  import i2cs_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter bit TAG_E2      = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [1:0]        mode_i,
  input  logic [2:0]        chip_en_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [7:0]        mem_wdata_o,
  output logic              mem_re_o,
  input  logic [7:0]        mem_rdata_i
);
  typedef logic [ADDR_W-1:0] addr_t;
  localparam addr_t ADDR_ONE = addr_t'(1);

  logic scl_s, sda_s, scl_rise, scl_fall, start, stop, frame_rst;
  logic byte_rdy, ack_rdy, ack_bit, bit_fall, slot_fall, end_fall, hit;
  logic [7:0] rx_byte;
  logic is_cmd;

  i2cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  assign frame_rst = start | stop;

  i2cs_framer u_framer (
    .clk_i, .rst_ni, .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .sda_i(sda_s),
    .frame_rst_i(frame_rst), .byte_rdy_o(byte_rdy), .rx_byte_o(rx_byte),
    .ack_rdy_o(ack_rdy), .ack_bit_o(ack_bit), .bit_fall_o(bit_fall),
    .slot_fall_o(slot_fall), .end_fall_o(end_fall)
  );

  i2cs_select #(.TAG_E2(TAG_E2)) u_select (
    .sel_byte_i(rx_byte), .mode_i, .chip_en_i, .hit_o(hit)
  );

  assign is_cmd = (mode_i == MODE_CMD);

  i2cs_state_e st_q;
  logic        ack_q, oe_q, pend_q, cmd_act_q, cmd_got_q;
  logic [7:0]  tx_q, hi_q;
  addr_t       ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      ack_q     <= 1'b0;
      oe_q      <= 1'b0;
      pend_q    <= 1'b0;
      cmd_act_q <= 1'b0;
      cmd_got_q <= 1'b0;
      tx_q      <= '0;
      hi_q      <= '0;
      ptr_q     <= '0;
    end else if (frame_rst) begin
      st_q      <= start ? ST_DEV : ST_IDLE;
      ack_q     <= 1'b0;
      oe_q      <= 1'b0;
      if (cmd_act_q && cmd_got_q) pend_q <= 1'b1;
      cmd_act_q <= 1'b0;
      cmd_got_q <= 1'b0;
    end else begin
      if (byte_rdy) begin
        case (st_q)
          ST_DEV: begin
            if (!hit) begin
              st_q <= ST_IDLE;
            end else if (!rx_byte[0]) begin
              ack_q <= 1'b1;
              if (is_cmd) begin
                st_q      <= ST_WDATA;
                ptr_q     <= '0;
                pend_q    <= 1'b0;
                cmd_act_q <= 1'b1;
              end else begin
                st_q <= ST_ADDR_HI;
              end
            end else if (is_cmd && !pend_q) begin
              st_q <= ST_IDLE;  // no reply prepared yet
            end else begin
              ack_q <= 1'b1;
              st_q  <= ST_RDATA;
              if (is_cmd) begin
                ptr_q  <= '0;
                pend_q <= 1'b0;
              end
            end
          end
          ST_ADDR_HI: begin
            hi_q  <= rx_byte;
            ack_q <= 1'b1;
            st_q  <= ST_ADDR_LO;
          end
          ST_ADDR_LO: begin
            ptr_q <= addr_t'({hi_q, rx_byte});
            ack_q <= 1'b1;
            st_q  <= ST_WDATA;
          end
          ST_WDATA: begin
            ack_q <= 1'b1;
            ptr_q <= ptr_q + ADDR_ONE;
            if (cmd_act_q) cmd_got_q <= 1'b1;
          end
          default: ack_q <= 1'b0;
        endcase
      end
      if (ack_rdy && ack_bit && st_q == ST_RDATA) st_q <= ST_IDLE;
      if (slot_fall) oe_q <= ack_q;
      if (end_fall) begin
        ack_q <= 1'b0;
        if (st_q == ST_RDATA) begin
          tx_q  <= {mem_rdata_i[6:0], 1'b0};
          oe_q  <= ~mem_rdata_i[7];
          ptr_q <= ptr_q + ADDR_ONE;
        end else begin
          oe_q <= 1'b0;
        end
      end
      if (bit_fall && st_q == ST_RDATA) begin
        oe_q <= ~tx_q[7];
        tx_q <= {tx_q[6:0], 1'b0};
      end
    end
  end

  assign sda_oe_o    = oe_q;
  assign mem_addr_o  = ptr_q;
  assign mem_we_o    = byte_rdy && (st_q == ST_WDATA);
  assign mem_wdata_o = rx_byte;
  assign mem_re_o    = end_fall && (st_q == ST_RDATA);

  AST_SDA_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(oe_q) && !$past(frame_rst)) |-> !scl_s); // R4

  AST_WE_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !sda_oe_o); // R5

  AST_NACK_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_rdy && ack_bit && st_q == ST_RDATA && !frame_rst) |=> (st_q == ST_IDLE && !oe_q)); // R7

  AST_BAD_TYPE_NOACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_rdy && st_q == ST_DEV && rx_byte[7:4] != DEV_TYPE) |=> !ack_q); // R2

  AST_CMD_READ_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_rdy && st_q == ST_DEV && is_cmd && rx_byte[0] && !pend_q) |=> !ack_q); // R9
endmodule

// File: tb/tb_i2cs_tag_slave.sv
`timescale 1ns/1ps
module tb_i2cs_tag_slave;
  localparam int         ADDR_W = 10;
  localparam bit         TAG_E2 = 1'b1;
  localparam logic [2:0] CE     = 3'b010;
  localparam int         Q      = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_bus;
  logic [1:0] mode = 2'd0;
  logic [ADDR_W-1:0] mem_addr;
  logic mem_we, mem_re;
  logic [7:0] mem_wdata, mem_rdata;
  logic [7:0] mem [1 << ADDR_W];
  int we_count = 0;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  assign sda_bus   = sda_m & ~sda_oe;
  assign mem_rdata = mem[mem_addr];

  i2cs_tag_slave #(.ADDR_W(ADDR_W), .TAG_E2(TAG_E2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .mode_i(mode), .chip_en_i(CE), .mem_addr_o(mem_addr), .mem_we_o(mem_we),
    .mem_wdata_o(mem_wdata), .mem_re_o(mem_re), .mem_rdata_i(mem_rdata)
  );

  always @(posedge clk) if (mem_we) begin
    mem[mem_addr] <= mem_wdata;
    we_count <= we_count + 1;
  end

  function automatic logic [7:0] pre(input int i);
    return 8'((i * 13 + 5) & 255);
  endfunction

  function automatic logic [7:0] dval(input int k);
    return 8'((8'hC3 + 37 * k) & 255);
  endfunction

  function automatic logic exp_hit(input logic [1:0] m, input logic [7:0] b);
    if (b[7:4] != 4'b1010) return 1'b0;
    if (m == 2'd1) return (b[3] == TAG_E2) && (b[2:1] == CE[1:0]);
    return b[3:1] == CE;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; sda_m = 1'b0; #Q; scl_m = 1'b0; #Q;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; #Q; scl_m = 1'b1; #Q; sda_m = 1'b1; #Q;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; #Q; scl_m = 1'b1; #(2*Q); scl_m = 1'b0; #Q;
    end
    sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; ack = !sda_bus; #Q; scl_m = 1'b0; #Q;
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      #Q; scl_m = 1'b1; #Q; b[i] = sda_bus; #Q; scl_m = 1'b0; #Q;
    end
    sda_m = !ack; #Q; scl_m = 1'b1; #(2*Q); scl_m = 1'b0; #Q; sda_m = 1'b1;
  endtask

  task automatic send_bits(input int n);
    for (int i = 0; i < n; i++) begin
      sda_m = 1'b1; #Q; scl_m = 1'b1; #(2*Q); scl_m = 1'b0; #Q;
    end
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] rb;
    for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = pre(i);
    #100; rst_n = 1'b1; #53;
    chk("R10 oe", int'(sda_oe), 0);
    chk("R10 we", int'(mem_we), 0);
    chk("R10 re", int'(mem_re), 0);

    // R2 R3 R4: select sweep, all modes, types and chip enables
    for (int m = 0; m < 3; m++) begin
      mode = 2'(m);
      for (int t = 0; t < 16; t++) begin
        logic [7:0] b;
        b = {4'(t), (m == 1) ? {TAG_E2, CE[1:0]} : CE, 1'b0};
        bus_start(); send_byte(b, ack); bus_stop();
        chk($sformatf("R2 R4 type m%0d b%0h", m, b), int'(ack), int'(exp_hit(2'(m), b)));
      end
      for (int c = 0; c < 8; c++) begin
        logic [7:0] b;
        b = {4'b1010, 3'(c), 1'b0};
        bus_start(); send_byte(b, ack); bus_stop();
        chk($sformatf("R3 R4 ce m%0d b%0h", m, b), int'(ack), int'(exp_hit(2'(m), b)));
      end
    end
    chk("R2 no writes during sweep", we_count, 0);

    // R2: rejected transfer ignores following bytes
    mode = 2'd0;
    bus_start(); send_byte(8'hB4, ack);
    chk("R2 bad type nack", int'(ack), 0);
    send_byte(8'h00, ack); chk("R2 ignored byte nack", int'(ack), 0);
    send_byte(8'h12, ack); chk("R2 ignored byte nack", int'(ack), 0);
    send_byte(8'h99, ack); chk("R2 ignored byte nack", int'(ack), 0);
    bus_stop();
    chk("R2 no write after reject", we_count, 0);

    // R5: write with truncated high byte and pointer wrap
    bus_start(); send_byte(8'hA4, ack); chk("R5 sel ack", int'(ack), 1);
    send_byte(8'h07, ack); chk("R5 addr hi ack", int'(ack), 1);
    send_byte(8'hFE, ack); chk("R5 addr lo ack", int'(ack), 1);
    for (int k = 0; k < 4; k++) begin
      send_byte(dval(k), ack); chk("R5 data ack", int'(ack), 1);
    end
    bus_stop();
    chk("R5 write count", we_count, 4);
    chk("R5 mem 3FE", int'(mem[10'h3FE]), int'(dval(0)));
    chk("R5 mem 3FF", int'(mem[10'h3FF]), int'(dval(1)));
    chk("R5 wrap mem 000", int'(mem[10'h000]), int'(dval(2)));
    chk("R5 wrap mem 001", int'(mem[10'h001]), int'(dval(3)));

    // R6: random read via repeated start
    bus_start(); send_byte(8'hA4, ack); send_byte(8'h03, ack); send_byte(8'hFE, ack);
    bus_start(); send_byte(8'hA5, ack); chk("R6 read sel ack", int'(ack), 1);
    for (int k = 0; k < 4; k++) begin
      recv_byte(k < 3, rb);
      chk($sformatf("R6 random read %0d", k), int'(rb), int'(dval(k)));
    end
    bus_stop();
    chk("R6 no write on address set", we_count, 4);

    // R6: current-address read continues at 002
    bus_start(); send_byte(8'hA5, ack); chk("R6 cur sel ack", int'(ack), 1);
    recv_byte(1'b0, rb); chk("R6 current read", int'(rb), int'(pre(2)));
    // R7: after NACK the slave stays off the bus
    recv_byte(1'b0, rb); chk("R7 released after nack", int'(rb), 8'hFF);
    bus_stop();

    // R1: partial byte abandoned by repeated start
    bus_start(); send_bits(5);
    bus_start(); send_byte(8'hA5, ack); chk("R1 resync after start", int'(ack), 1);
    recv_byte(1'b0, rb); chk("R1 read after resync", int'(rb), int'(pre(3)));
    bus_stop();
    // R1: partial byte abandoned by stop
    bus_start(); send_bits(3); bus_stop();
    bus_start(); send_byte(8'hA4, ack); chk("R1 resync after stop", int'(ack), 1);
    bus_stop();

    // R3 R5 R6: tag mode uses internal E2
    mode = 2'd1;
    bus_start(); send_byte(8'hAC, ack); chk("R3 tag sel ack", int'(ack), 1);
    send_byte(8'h00, ack); send_byte(8'h10, ack);
    send_byte(8'h77, ack); chk("R5 tag data ack", int'(ack), 1);
    bus_stop();
    bus_start(); send_byte(8'hAC, ack); send_byte(8'h00, ack); send_byte(8'h10, ack);
    bus_start(); send_byte(8'hAD, ack); chk("R3 tag read sel ack", int'(ack), 1);
    recv_byte(1'b0, rb); chk("R6 tag read back", int'(rb), 8'h77);
    bus_stop();

    // R8 R9: command/response
    mode = 2'd2;
    bus_start(); send_byte(8'hA5, ack); chk("R9 read before command nack", int'(ack), 0);
    bus_stop();
    bus_start(); send_byte(8'hA4, ack); chk("R8 cmd sel ack", int'(ack), 1);
    for (int k = 0; k < 3; k++) begin
      send_byte(8'(8'h30 + k), ack); chk("R8 cmd byte ack", int'(ack), 1);
    end
    bus_stop();
    for (int k = 0; k < 3; k++)
      chk($sformatf("R8 cmd stored at %0d", k), int'(mem[k]), 8'h30 + k);
    bus_start(); send_byte(8'hA5, ack); chk("R9 reply sel ack", int'(ack), 1);
    for (int k = 0; k < 3; k++) begin
      recv_byte(k < 2, rb); chk($sformatf("R9 reply %0d", k), int'(rb), 8'h30 + k);
    end
    bus_stop();
    bus_start(); send_byte(8'hA5, ack); chk("R9 reply consumed nack", int'(ack), 0);
    bus_stop();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule